// File: doc/BRIEF.md
# Serial ADC Conversion Read Controller

This block is the host side of a serial analog-to-digital converter that is driven by two control lines: a conversion strobe and a serial clock. It raises the strobe when the system asks for a sample. The rising strobe brings the converter out of the low-power state it powers up in, and it then tracks its input. After a programmed number of system cycles the block lowers the strobe, which freezes the input and starts the conversion. It then clocks out one frame of sixteen serial clocks, reading the converter's data line.

Each bit on the data line changes just after one serial-clock rise and holds until just after the next rise. The block therefore reads every bit on the rise that follows the one that produced it. The first three bits of a frame must be zero. The twelve bits after them are the result, most significant bit first. When the frame ends, the block loads the result, raises a one-cycle valid pulse and reports whether any of the leading bits came back as one. A start request is accepted only when the block is idle.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, the strobe, serial clock, busy, valid, error flag and result are all zero.
- R2: A start request seen while idle raises the strobe and busy on the next clock edge, so every conversion begins with a rising strobe edge.
- R3: The strobe stays high for exactly ACQ_CYCLES system cycles and then falls. The serial clock stays low for as long as the strobe is high.
- R4: After the strobe falls, exactly 16 serial-clock rising edges are produced. Each high phase and each low phase lasts DIV_HALF system cycles. Between frames the serial clock rests low.
- R5: The data line is sampled at each serial-clock rise. The samples taken at rises 5 through 16 are data bits 11 down to 0, in that order, and they form the result.
- R6: When the high phase of the 16th serial-clock pulse ends, valid is high for exactly one cycle. In that same cycle the result is updated and busy is low. The result then holds until the next frame completes.
- R7: A start request made while busy is ignored. The frame in progress is unchanged, the strobe rises once per conversion, and no new conversion follows on its own.
- R8: The error flag updates together with valid. It is one when any of the samples taken at rises 2, 3 and 4 (the three leading bits) is one, and zero after a frame in which all three are zero.
- R9: A start request made in the valid cycle is accepted and begins a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one conversion |
| busy_o | output | 1 | A conversion is in progress |
| valid_o | output | 1 | One-cycle pulse: new result available |
| result_o | output | 12 | Last conversion result |
| err_o | output | 1 | A leading bit of the last frame was one |
| cnvst_o | output | 1 | Conversion strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| dout_i | input | 1 | Serial data from the converter |

## Verification
On every cycle the assertions check these relationships between the control lines: the serial clock stays low whenever the strobe is high or the block is idle, valid lasts a single cycle and never overlaps busy, the strobe rises only in response to a start request, and the rise counter never exceeds a frame. Some properties can only be shown by the bench's scenarios, which run against a model of the converter. These are whether the result has the right bit order, the exact acquisition length and serial-clock count, the detection of a one among the leading bits and its clearing on the next frame, and the handling of a start made during a frame or in the valid cycle.

// File: rtl/adc_rd_pkg.sv
// Package: shared types for the serial ADC read controller.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_rd_pkg;

    // Controller sequence: idle, strobe-high acquisition, serial frame.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_FRAME = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/adc_sclk_div.sv
// Module: serial clock divider.
// Generates a serial clock whose high and low phases each last HALF_CYC
// system cycles while run_i is high. The clock starts in its low phase.
// It reports the system cycle in which each rising or falling transition
// is registered.
// Assumes: HALF_CYC >= 1; run_i is low when no frame is active.
module adc_sclk_div #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(HALF_CYC + 1);

    logic [CW-1:0] phase_cnt;
    logic          sclk_q;
    logic          edge_due;

    // Phase boundary reached on this cycle.
    assign edge_due = run_i && (phase_cnt == CW'(HALF_CYC - 1));
    assign rise_o   = edge_due && !sclk_q;
    assign fall_o   = edge_due && sclk_q;
    assign sclk_o   = sclk_q;

    // Count system cycles in the current phase and toggle at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_cnt <= '0;
            sclk_q    <= 1'b0;
        end else if (edge_due) begin
            phase_cnt <= '0;
            sclk_q    <= ~sclk_q;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

    // R4: the clock rests low whenever no frame is running.
    a_r4_rest_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sclk_q);

    // R4: a transition lands only where a phase boundary was flagged.
    a_r4_edge_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q != $past(sclk_q)) |-> $past(rise_o || fall_o));

endmodule

// File: rtl/adc_rx_shift.sv
// Module: frame receiver.
// Counts serial-clock rises in a frame. At every rise it samples the data
// line, which still carries the bit produced by the previous rise. Samples
// at rises 2..LEAD+1 are leading bits that must be zero. The next DW
// samples are shifted in MSB first.
// Assumes: clear_i pulses before each frame; rise_i is one cycle per rise.
module adc_rx_shift #(
    parameter int FRAME_CLKS = 16,
    parameter int LEAD       = 3,
    parameter int DW         = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clear_i,
    input  logic                                rise_i,
    input  logic                                sdi_i,
    output logic [DW-1:0]                       data_o,
    output logic                                lead_err_o,
    output logic [$clog2(FRAME_CLKS + 1)-1:0]   rises_o
);
    localparam int CNTW = $clog2(FRAME_CLKS + 1);

    logic [CNTW-1:0] rise_cnt;
    logic [DW-1:0]   shreg;
    logic            err_q;
    logic            in_lead;
    logic            in_data;

    // Classify the sample by how many rises preceded it in this frame.
    assign in_lead = (rise_cnt >= CNTW'(1)) && (rise_cnt <= CNTW'(LEAD));
    assign in_data = (rise_cnt > CNTW'(LEAD)) && (rise_cnt <= CNTW'(LEAD + DW));

    // Count rises, check leading bits and shift in data bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            rise_cnt <= '0;
            shreg    <= '0;
            err_q    <= 1'b0;
        end else if (rise_i) begin
            rise_cnt <= rise_cnt + 1'b1;
            if (in_lead) begin
                err_q <= err_q | sdi_i;
            end else if (in_data) begin
                shreg <= {shreg[DW-2:0], sdi_i};
            end
        end
    end

    assign data_o     = shreg;
    assign lead_err_o = err_q;
    assign rises_o    = rise_cnt;

    // R4: the rise count never passes one frame.
    a_r4_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rise_cnt <= CNTW'(FRAME_CLKS));

endmodule

// File: rtl/adc_frame_ctrl.sv
// Module: serial ADC read controller (top).
// A start request raises the conversion strobe. The rising strobe wakes
// the converter and begins acquisition. After ACQ_CYCLES system cycles the
// strobe falls, and one FRAME_CLKS-pulse serial frame follows. At the end
// of the last high phase the result and the leading-bit error are loaded
// and valid pulses for one cycle.
// Assumes: dout_i changes shortly after each sclk_o rise and holds past
// the next rise; DIV_HALF gives the converter enough setup time.
module adc_frame_ctrl #(
    parameter int DIV_HALF   = 2,
    parameter int ACQ_CYCLES = 8,
    parameter int FRAME_CLKS = 16,
    parameter int LEAD       = 3,
    parameter int DW         = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy_o,
    output logic          valid_o,
    output logic [DW-1:0] result_o,
    output logic          err_o,
    output logic          cnvst_o,
    output logic          sclk_o,
    input  logic          dout_i
);
    import adc_rd_pkg::*;

    localparam int ACQW = $clog2(ACQ_CYCLES + 1);
    localparam int CNTW = $clog2(FRAME_CLKS + 1);

    ctrl_state_e     state;
    logic [ACQW-1:0] acq_cnt;
    logic            cnvst_q;
    logic            busy_q;
    logic            valid_q;
    logic [DW-1:0]   result_q;
    logic            err_q;
    logic            sclk_rise;
    logic            sclk_fall;
    logic            run_clk;
    logic            accept;
    logic            frame_end;
    logic [DW-1:0]   rx_data;
    logic            rx_err;
    logic [CNTW-1:0] rx_rises;

    assign run_clk   = (state == ST_FRAME);
    assign accept    = (state == ST_IDLE) && start_i;
    assign frame_end = run_clk && sclk_fall && (rx_rises == CNTW'(FRAME_CLKS));

    adc_sclk_div #(.HALF_CYC(DIV_HALF)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_clk),
        .sclk_o (sclk_o),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    adc_rx_shift #(.FRAME_CLKS(FRAME_CLKS), .LEAD(LEAD), .DW(DW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept),
        .rise_i     (sclk_rise),
        .sdi_i      (dout_i),
        .data_o     (rx_data),
        .lead_err_o (rx_err),
        .rises_o    (rx_rises)
    );

    // Sequence strobe, acquisition timing, frame completion and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            acq_cnt  <= '0;
            cnvst_q  <= 1'b0;
            busy_q   <= 1'b0;
            valid_q  <= 1'b0;
            result_q <= '0;
            err_q    <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        cnvst_q <= 1'b1;
                        busy_q  <= 1'b1;
                        acq_cnt <= '0;
                        state   <= ST_ACQ;
                    end
                end
                ST_ACQ: begin
                    if (acq_cnt == ACQW'(ACQ_CYCLES - 1)) begin
                        cnvst_q <= 1'b0;
                        state   <= ST_FRAME;
                    end else begin
                        acq_cnt <= acq_cnt + 1'b1;
                    end
                end
                ST_FRAME: begin
                    if (frame_end) begin
                        result_q <= rx_data;
                        err_q    <= rx_err;
                        valid_q  <= 1'b1;
                        busy_q   <= 1'b0;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o   = busy_q;
    assign valid_o  = valid_q;
    assign result_o = result_q;
    assign err_o    = err_q;
    assign cnvst_o  = cnvst_q;

    // R3: no serial clock while the strobe is high.
    a_r3_quiet_in_acq: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst_q |-> !sclk_o);

    // R4: the serial clock only toggles during a conversion.
    a_r4_clock_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> busy_q);

    // R6: valid is a single-cycle pulse.
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R6: busy is already low in the valid cycle.
    a_r6_valid_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> !busy_q);

    // R2 and R7: the strobe rises only after a start request from idle.
    a_r2_strobe_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnvst_q) |-> $past(start_i && !busy_q));

endmodule

// File: tb/sim_adc_frame_ctrl.sv
`timescale 1ns/100ps
module sim_adc_frame_ctrl;
    localparam int HALF = 2;
    localparam int ACQ  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, valid, err, cnvst, sclk;
    logic [11:0] result;
    logic        dout = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    adc_frame_ctrl #(.DIV_HALF(HALF), .ACQ_CYCLES(ACQ)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
        .valid_o(valid), .result_o(result), .err_o(err),
        .cnvst_o(cnvst), .sclk_o(sclk), .dout_i(dout)
    );

    // Converter model: wakes on a strobe rise, loads a frame on the fall,
    // and drives the next frame bit 1 ns after each serial-clock rise.
    logic [11:0] adc_data = '0;
    logic        adc_bad = 1'b0;
    logic        adc_awake = 1'b0;
    logic [15:0] adc_word = '0;
    int          adc_idx = 0;

    always @(posedge cnvst) adc_awake = 1'b1;

    always @(posedge sclk or negedge cnvst) begin
        if (sclk) begin
            #1;
            if (adc_idx < 16) dout = adc_word[15 - adc_idx];
            adc_idx = adc_idx + 1;
        end else if (adc_awake) begin
            adc_word = {3'b000, adc_data, 1'b0};
            if (adc_bad) adc_word[14] = 1'b1;
            adc_idx = 0;
            dout = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one conversion and returns what was observed at the ports.
    // poke: raise start for one cycle in the middle of the frame.
    task automatic run_conv(input logic [11:0] d, input logic bad, input bit poke,
                            output logic [11:0] r, output logic e,
                            output int hi, output int rises, output int shi,
                            output int overlap, output int crise);
        logic psclk, pcnvst;
        adc_data = d;
        adc_bad  = bad;
        hi = 0; rises = 0; shi = 0; overlap = 0; crise = 0;
        psclk = 1'b0; pcnvst = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy === 1'b1 && cnvst === 1'b1, "R2", int'(cnvst), 1);
        for (int i = 0; i < 2000; i++) begin
            if (i > 0) @(negedge clk);
            start = 1'b0;
            if (cnvst) hi++;
            if (cnvst && !pcnvst) crise++;
            if (sclk && !psclk) rises++;
            if (sclk) shi++;
            if (sclk && cnvst) overlap++;
            if (poke && rises == 5 && sclk && !psclk) start = 1'b1;
            psclk = sclk; pcnvst = cnvst;
            if (valid) break;
        end
        check(valid === 1'b1 && busy === 1'b0, "R6", int'(busy), 0);
        r = result;
        e = err;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cnvst === 0 && sclk === 0 && busy === 0, "R1", int'({cnvst, sclk, busy}), 0);
        check(valid === 0 && err === 0 && result === 12'h000, "R1", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_pattern(input logic [11:0] d);
        logic [11:0] r; logic e; int hi, rises, shi, ov, cr;
        run_conv(d, 1'b0, 1'b0, r, e, hi, rises, shi, ov, cr);
        check(r === d, "R5", int'(r), int'(d));
        check(e === 1'b0, "R8", int'(e), 0);
        check(hi == ACQ && ov == 0, "R3", hi, ACQ);
        check(rises == 16 && shi == 16 * HALF, "R4", rises, 16);
        @(negedge clk);
        check(valid === 1'b0 && result === d && sclk === 1'b0, "R6", int'(valid), 0);
    endtask

    task automatic t_busy_ignore();
        logic [11:0] r; logic e; int hi, rises, shi, ov, cr;
        run_conv(12'h5A3, 1'b0, 1'b1, r, e, hi, rises, shi, ov, cr);
        check(r === 12'h5A3, "R7", int'(r), 'h5A3);
        check(cr == 1 && rises == 16, "R7", rises, 16);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check(cnvst === 1'b0 && busy === 1'b0, "R7", int'(cnvst), 0);
        end
    endtask

    task automatic t_error();
        logic [11:0] r; logic e; int hi, rises, shi, ov, cr;
        run_conv(12'h0F0, 1'b1, 1'b0, r, e, hi, rises, shi, ov, cr);
        check(e === 1'b1, "R8", int'(e), 1);
        check(r === 12'h0F0, "R5", int'(r), 'h0F0);
        run_conv(12'h00F, 1'b0, 1'b0, r, e, hi, rises, shi, ov, cr);
        check(e === 1'b0, "R8", int'(e), 0);
    endtask

    task automatic t_back_to_back();
        logic [11:0] r; logic e; int hi, rises, shi, ov, cr;
        run_conv(12'h3C6, 1'b0, 1'b0, r, e, hi, rises, shi, ov, cr);
        // start asserted during the valid cycle
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(cnvst === 1'b1 && busy === 1'b1, "R9", int'(cnvst), 1);
        for (int k = 0; k < 2000 && !valid; k++) @(negedge clk);
        check(result === 12'h3C6 && valid === 1'b1, "R9", int'(result), 'h3C6);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_pattern(12'hA5C);
        t_pattern(12'hFFF);
        t_pattern(12'h000);
        t_pattern(12'h801);
        t_busy_ignore();
        t_error();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule